// File: doc/BRIEF.md
# Clock Burst Sequencer

The block plays out a programmed list of clock bursts on one digital output bound for a general-purpose I/O pin. Each list entry gives a half-period length, counted in system clocks, and a number of full periods. After a start request the block walks the list from entry 0 upward. For each entry it drives that many complete periods, each made of a high phase and then a low phase of equal length. It then moves on to the next entry, so the result is a chain of slower clocks, each with its own rate and length.

A host fills the list through a simple write port and sets how many entries are in use through a length register. It then pulses start. A busy flag covers the whole run, and a one-cycle done pulse marks its end. Entries with a period count of zero take no time at all.

Top module: `clk_burst_seq`

## Requirements
- R1: After reset, clk_o, busy_o and done_o are all 0, every entry's period count is 0, and the length register is 0.
- R2: An entry with half-period h (16 bits) and count n yields n periods, each of h cycles high followed by h cycles low. The first high cycle is the cycle after the clock edge that samples start_i.
- R3: Entries run in ascending index order. The high phase of the next used entry begins in the cycle right after the last low cycle of the previous one, with no gap.
- R4: An entry whose period count is 0 is skipped and uses no cycles.
- R5: Only entries with index below the length register are used. len_we_i loads len_i into the register, and values above the list depth (64) are clamped to 64.
- R6: A half-period field of 0 behaves as 1.
- R7: busy_o is high from the first high cycle through the last low cycle. done_o is high for exactly the one cycle after that, with busy_o low in that cycle. clk_o is 0 whenever busy_o is 0.
- R8: While busy_o is high, start_i, entry writes and length writes are ignored. The running burst is not changed, and a later run uses the old contents.
- R9: If no entry in range has a non-zero count, start yields a done_o pulse in the next cycle and busy_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one list entry |
| wr_addr_i | input | 6 | Entry index to write |
| wr_half_i | input | 16 | Half-period in system clocks |
| wr_count_i | input | 16 | Number of full periods |
| len_we_i | input | 1 | Load the length register |
| len_i | input | 7 | Number of entries in use |
| start_i | input | 1 | Start a run (sampled while idle) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| clk_o | output | 1 | Generated burst clock |

## Verification
After start_i is sampled at an edge, the first high cycle of clk_o is due in the very next cycle. From then on, every cycle's expected clk_o and busy_o come from adding up h and n over the bench's own copy of the list. The done pulse is due exactly one cycle after the last expected low cycle, and an empty list puts it in the first cycle after the start edge. The bench drives inputs and samples outputs on the falling edge. It steps once per cycle along that computed sequence, so each comparison lands in exactly the cycle where the result is due.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int HALF_W = 16;
  localparam int CNT_W  = 16;

  typedef struct packed {
    logic [HALF_W-1:0] half;
    logic [CNT_W-1:0]  cnt;
  } cbs_entry_t;
endpackage

// File: rtl/cbs_entry_ram.sv
module cbs_entry_ram
  import cbs_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  cbs_entry_t       wdata_i,
  input  logic             len_we_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output cbs_entry_t       rd_o,
  output logic [DEPTH-1:0] nz_o
);
  cbs_entry_t       mem_q [DEPTH];
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
    end else if (len_we_i) begin
      len_q <= (len_i > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : len_i;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_i && waddr_i == IDX_W'(g)) mem_q[g] <= wdata_i;
    end
    assign nz_o[g] = (mem_q[g].cnt != '0) && (LEN_W'(g) < len_q);
  end

  assign rd_o = mem_q[rd_idx_i];

  assert_len_clamped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= LEN_W'(DEPTH));
endmodule

// File: rtl/cbs_pick.sv
module cbs_pick #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] mask_i,
  input  logic [IDX_W:0]   from_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest usable entry at or above from_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (mask_i[i] && (i >= int'(from_i))) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (found_o) begin
      assert_pick_valid_R4: assert (mask_i[idx_o] && ({1'b0, idx_o} >= from_i));
    end
  end
endmodule

// File: rtl/cbs_engine.sv
module cbs_engine
  import cbs_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             found_i,
  input  logic [IDX_W-1:0] pick_i,
  input  cbs_entry_t       ent_i,
  output logic [IDX_W:0]   from_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             clk_o
);
  logic              busy_q, done_q, out_q;
  logic [IDX_W-1:0]  idx_q;
  logic [HALF_W-1:0] half_q, tmr_q, eff_half;
  logic [CNT_W-1:0]  per_q;

  assign eff_half = (ent_i.half == '0) ? HALF_W'(1) : ent_i.half;
  assign from_o   = busy_q ? ({1'b0, idx_q} + 1'b1) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      out_q  <= 1'b0;
      idx_q  <= '0;
      half_q <= HALF_W'(1);
      tmr_q  <= '0;
      per_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          if (found_i) begin
            busy_q <= 1'b1;
            out_q  <= 1'b1;
            idx_q  <= pick_i;
            half_q <= eff_half;
            tmr_q  <= eff_half - 1'b1;
            per_q  <= ent_i.cnt;
          end else begin
            done_q <= 1'b1;
          end
        end
      end else if (tmr_q != '0) begin
        tmr_q <= tmr_q - 1'b1;
      end else if (out_q) begin
        out_q <= 1'b0;
        tmr_q <= half_q - 1'b1;
      end else if (per_q != CNT_W'(1)) begin
        per_q <= per_q - 1'b1;
        out_q <= 1'b1;
        tmr_q <= half_q - 1'b1;
      end else if (found_i) begin
        // next used entry starts with no gap
        out_q  <= 1'b1;
        idx_q  <= pick_i;
        half_q <= eff_half;
        tmr_q  <= eff_half - 1'b1;
        per_q  <= ent_i.cnt;
      end else begin
        busy_q <= 1'b0;
        out_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign clk_o  = out_q;

  assert_idle_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !clk_o);
  assert_done_not_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);
  assert_busy_needs_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  assert_timer_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (tmr_q < half_q));
  assert_hold_mid_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tmr_q != '0) |=> $stable(clk_o));
endmodule

// File: rtl/clk_burst_seq.sv
module clk_burst_seq
  import cbs_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [HALF_W-1:0] wr_half_i,
  input  logic [CNT_W-1:0]  wr_count_i,
  input  logic              len_we_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              clk_o
);
  cbs_entry_t       wdata, rd_ent;
  logic [DEPTH-1:0] nz;
  logic [IDX_W:0]   from;
  logic             found;
  logic [IDX_W-1:0] pick;

  assign wdata = '{half: wr_half_i, cnt: wr_count_i};

  // host writes are locked out during a run
  cbs_entry_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en_i && !busy_o),
    .waddr_i  (wr_addr_i),
    .wdata_i  (wdata),
    .len_we_i (len_we_i && !busy_o),
    .len_i    (len_i),
    .rd_idx_i (pick),
    .rd_o     (rd_ent),
    .nz_o     (nz)
  );

  cbs_pick #(.DEPTH(DEPTH)) u_pick (
    .mask_i  (nz),
    .from_i  (from),
    .found_o (found),
    .idx_o   (pick)
  );

  cbs_engine #(.DEPTH(DEPTH)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .found_i (found),
    .pick_i  (pick),
    .ent_i   (rd_ent),
    .from_o  (from),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .clk_o   (clk_o)
  );
endmodule

// File: tb/clk_burst_seq_bench.sv
module clk_burst_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_addr_i = '0;
  logic [15:0] wr_half_i = '0;
  logic [15:0] wr_count_i = '0;
  logic        len_we_i = 1'b0;
  logic [6:0]  len_i = '0;
  logic        start_i = 1'b0;
  logic        busy_o, done_o, clk_o;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int hm [64];
  int nm [64];
  int lenm = 0;

  always #2 clk_i = ~clk_i;

  clk_burst_seq u_clk_burst_seq (.*);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at cycle %0d: actual clk/busy/done=%b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic wr(int a, int h, int n);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 6'(a); wr_half_i = 16'(h); wr_count_i = 16'(n);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    hm[a] = h; nm[a] = n;
  endtask

  task automatic set_len(int l);
    @(negedge clk_i);
    len_we_i = 1'b1; len_i = 7'(l);
    @(negedge clk_i);
    len_we_i = 1'b0;
    lenm = (l > 64) ? 64 : l;
  endtask

  // poke: try start, an entry write and a length write during the run (R8)
  task automatic run(string req, bit poke);
    bit first = 1'b1;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < lenm; i++) begin
      int he = (hm[i] == 0) ? 1 : hm[i];
      for (int p = 0; p < nm[i]; p++) begin
        for (int ph = 0; ph < 2; ph++) begin
          for (int c = 0; c < he; c++) begin
            chk(req, {clk_o, busy_o, done_o}, {(ph == 0), 1'b1, 1'b0});
            if (poke && first) begin
              start_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = '0;
              wr_half_i = 16'd7; wr_count_i = 16'd9;
              len_we_i = 1'b1; len_i = 7'd1;
            end
            @(negedge clk_i);
            if (poke && first) begin
              start_i = 1'b0; wr_en_i = 1'b0; len_we_i = 1'b0;
              first = 1'b0;
            end
          end
        end
      end
    end
    chk({req, " R7 done"}, {clk_o, busy_o, done_o}, 3'b001);
    @(negedge clk_i);
    chk({req, " R7 after"}, {clk_o, busy_o, done_o}, 3'b000);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin hm[i] = 0; nm[i] = 0; end
    repeat (3) @(negedge clk_i);
    chk("R1 reset", {clk_o, busy_o, done_o}, 3'b000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 post-reset", {clk_o, busy_o, done_o}, 3'b000);

    // R9: empty length register after reset
    run("R9 len0", 1'b0);

    // R2: sweep single entry
    set_len(1);
    for (int h = 1; h <= 4; h++)
      for (int n = 1; n <= 3; n++) begin
        wr(0, h, n);
        run("R2 single", 1'b0);
      end

    // R6: zero half-period acts as one
    wr(0, 0, 3);
    run("R6 half0", 1'b0);

    // R3/R4/R5: ordered list with skipped entries, tail beyond length unused
    wr(0, 2, 2); wr(1, 3, 0); wr(2, 1, 3); wr(3, 0, 0); wr(4, 3, 1); wr(5, 5, 5);
    set_len(5);
    run("R3 R4 R5 list", 1'b0);

    // R8: start and writes during a run ignored, then rerun old contents
    run("R8 poke", 1'b1);
    run("R8 rerun", 1'b0);

    // R9: entries in range all zero count
    wr(0, 4, 0); wr(2, 2, 0); wr(4, 3, 0);
    set_len(5);
    run("R9 allzero", 1'b0);

    // R5: full list, length clamped from 100 to 64
    for (int i = 0; i < 64; i++) wr(i, (i % 3) + 1, (i % 4 == 2) ? 0 : 1);
    set_len(100);
    run("R5 full clamp", 1'b0);
    set_len(64);
    wr(63, 2, 2);
    run("R5 last entry", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule